// File: doc/BRIEF.md
# Audio Port Interrupt Mask and Status Unit

This block collects event indications from a multi-channel audio serial port and turns them into a single interrupt request. It holds two 32-bit event groups. The first group carries four fields for each channel: transmit-ready, transmit-underrun, receive-ready and receive-overflow. The second group carries FIFO events and a write-error flag. Each group has a status view and an interrupt mask. The interrupt line is raised when some bit is set in both the mask and the status of the same group.

Software never writes the mask directly. Each group offers a set-strobe register, where a 1 enables a mask bit, and a clear-strobe register, where a 1 disables one. The mask itself can only be read. Ready-type status bits follow their source inputs. Error-type status bits (underrun, overflow, write error) catch single-cycle pulses and stay set until software reads the status register.

The register port is a simple single-cycle valid/write/address/data interface with registered read data.

Top module: `aud_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every mask bit and every sticky status bit is 0, and `irq_o` and `bus_rdata` are 0.
- R2: A write to the enable register (group A offset 0x10, group B offset 0x20) sets each mask bit whose write-data bit is 1 and leaves the others unchanged. The mask reads back at offset 0x18 (A) or 0x28 (B).
- R3: A write to the disable register (A 0x14, B 0x24) clears each mask bit whose write-data bit is 1 and leaves the others unchanged.
- R4: The group A status (offset 0x1C) holds transmit-ready of channel n at bit n, transmit-underrun at bit 8+n, receive-ready at bit 16+n and receive-overflow at bit 24+n.
- R5: The group B status (offset 0x2C) holds write-error at bit 0, transmit-FIFO-ready at bit 8, transmit-FIFO-empty at bit 9, receive-FIFO-ready at bit 12 and receive-FIFO-full at bit 13. All other bits of the group B status and mask read as 0, even after an enable write of all ones.
- R6: Ready, FIFO-ready, FIFO-empty and FIFO-full status bits are level bits. A read returns the value their inputs have in the cycle of the read, and a read does not clear them.
- R7: Underrun, overflow and write-error status bits are sticky. A one-cycle input pulse sets the bit, and the bit stays set until its group's status register is read. That read returns the bit and clears it. A pulse arriving in the same cycle as the read is kept and shows up in the next read.
- R8: `irq_o` is 1 in the cycle after a cycle in which any group has a bit set in both its mask and its status, and 0 otherwise.
- R9: Writes to the mask or status offsets, and any access to an unmapped offset, change nothing. Reads of unmapped, enable or disable offsets return 0.
- R10: Read data appears on `bus_rdata` in the cycle after the read access. It holds its value until the next read, and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_rdy_i | input | 8 | Per-channel transmit-ready levels |
| tx_unf_i | input | 8 | Per-channel transmit-underrun pulses |
| rx_rdy_i | input | 8 | Per-channel receive-ready levels |
| rx_ovf_i | input | 8 | Per-channel receive-overflow pulses |
| wr_err_i | input | 1 | Write-error pulse |
| txf_rdy_i | input | 1 | Transmit FIFO ready level |
| txf_emp_i | input | 1 | Transmit FIFO empty level |
| rxf_rdy_i | input | 1 | Receive FIFO ready level |
| rxf_ful_i | input | 1 | Receive FIFO full level |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every result of this block arrives a fixed number of edges after its cause. Read data arrives one edge after the read. A mask write takes effect one edge after the write and reaches `irq_o` one edge later. A level input reaches `irq_o` after one edge. A sticky pulse is captured at the first edge and drives `irq_o` after the second. The bench drives inputs on the falling edge, updates a behavioural model at each rising edge from the inputs it can see, and compares `bus_rdata` and `irq_o` with that model at every falling edge. Directed reads check the literal values that each requirement predicts, exactly one cycle after the access.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

  localparam int unsigned DW      = 32;
  localparam int unsigned AW      = 8;
  localparam int unsigned NGRP    = 2;
  localparam int unsigned FLD_W   = 8;

  // group base offsets: slot index = addr[7:4]
  localparam logic [AW-1:0] GRP0_BASE = 8'h10;

  // register order inside a group (order is behaviour)
  typedef enum logic [1:0] {
    REG_SET = 2'd0,
    REG_CLR = 2'd1,
    REG_MSK = 2'd2,
    REG_STS = 2'd3
  } reg_sel_e;

  // group A field bases
  localparam int unsigned FA_TXRDY = 0;
  localparam int unsigned FA_TXUNF = 8;
  localparam int unsigned FA_RXRDY = 16;
  localparam int unsigned FA_RXOVF = 24;

  // group B bit positions
  localparam int unsigned FB_WERR   = 0;
  localparam int unsigned FB_TXFRDY = 8;
  localparam int unsigned FB_TXFEMP = 9;
  localparam int unsigned FB_RXFRDY = 12;
  localparam int unsigned FB_RXFFUL = 13;

  function automatic logic [DW-1:0] chan_bits(input int unsigned base, input int unsigned nch);
    logic [DW-1:0] v;
    v = '0;
    for (int c = 0; c < int'(nch); c++) v[base + c] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] grp_a_valid(input int unsigned nch);
    return chan_bits(FA_TXRDY, nch) | chan_bits(FA_TXUNF, nch) |
           chan_bits(FA_RXRDY, nch) | chan_bits(FA_RXOVF, nch);
  endfunction

  function automatic logic [DW-1:0] grp_a_sticky(input int unsigned nch);
    return chan_bits(FA_TXUNF, nch) | chan_bits(FA_RXOVF, nch);
  endfunction

  function automatic logic [DW-1:0] grp_b_valid();
    logic [DW-1:0] v;
    v = '0;
    v[FB_WERR]   = 1'b1;
    v[FB_TXFRDY] = 1'b1;
    v[FB_TXFEMP] = 1'b1;
    v[FB_RXFRDY] = 1'b1;
    v[FB_RXFFUL] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] grp_b_sticky();
    logic [DW-1:0] v;
    v = '0;
    v[FB_WERR] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/aud_irq_regif.sv
module aud_irq_regif
  import aud_irq_pkg::*;
#(
  parameter int unsigned P_AW   = AW,
  parameter int unsigned P_DW   = DW,
  parameter int unsigned P_NGRP = NGRP
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_vld,
  input  logic                          bus_wr,
  input  logic [P_AW-1:0]               bus_addr,
  input  logic [P_NGRP-1:0][P_DW-1:0]   grp_mask,
  input  logic [P_NGRP-1:0][P_DW-1:0]   grp_sts,
  output logic [P_NGRP-1:0]             set_stb,
  output logic [P_NGRP-1:0]             clr_stb,
  output logic [P_NGRP-1:0]             rdclr_stb,
  output logic [P_DW-1:0]               rdata_q
);

  localparam int unsigned SLOT_W    = P_AW - 4;
  localparam logic [SLOT_W-1:0] SLOT0 = SLOT_W'(GRP0_BASE >> 4);

  logic [SLOT_W-1:0] slot;
  reg_sel_e          rsel;
  logic              aligned;
  logic [P_NGRP-1:0] hit;
  logic [P_DW-1:0]   rd_mux;

  assign slot    = bus_addr[P_AW-1:4];
  assign rsel    = reg_sel_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < int'(P_NGRP); g++) begin : g_dec
    assign hit[g]       = bus_vld && aligned && (slot == SLOT0 + SLOT_W'(g));
    assign set_stb[g]   = hit[g] &&  bus_wr && (rsel == REG_SET);
    assign clr_stb[g]   = hit[g] &&  bus_wr && (rsel == REG_CLR);
    assign rdclr_stb[g] = hit[g] && !bus_wr && (rsel == REG_STS);
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < int'(P_NGRP); g++) begin
      if (hit[g] && !bus_wr) begin
        case (rsel)
          REG_MSK: rd_mux = grp_mask[g];
          REG_STS: rd_mux = grp_sts[g];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_vld && !bus_wr) rdata_q <= rd_mux;
  end

  // only one strobe of any kind per access
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_stb, clr_stb, rdclr_stb}));

  // read data is held across cycles without a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_vld && !bus_wr) |=> $stable(rdata_q));

endmodule

// File: rtl/aud_irq_bank.sv
module aud_irq_bank
  import aud_irq_pkg::*;
#(
  parameter int unsigned   P_DW   = DW,
  parameter logic [P_DW-1:0] VALID  = '1,
  parameter logic [P_DW-1:0] STICKY = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [P_DW-1:0] src_lvl,
  input  logic [P_DW-1:0] src_evt,
  input  logic            set_stb,
  input  logic            clr_stb,
  input  logic            rd_clr,
  input  logic [P_DW-1:0] wdata,
  output logic [P_DW-1:0] mask_q,
  output logic [P_DW-1:0] sts_o,
  output logic            pend_o
);

  localparam logic [P_DW-1:0] LEVEL = VALID & ~STICKY;
  localparam logic [P_DW-1:0] KEEP  = VALID & STICKY;

  logic [P_DW-1:0] stk_q;
  logic [P_DW-1:0] set_v, clr_v;

  assign set_v  = set_stb ? wdata : '0;
  assign clr_v  = clr_stb ? wdata : '0;
  assign sts_o  = (src_lvl & LEVEL) | stk_q;
  assign pend_o = |(mask_q & sts_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stk_q  <= '0;
    end else begin
      // disable wins over enable on the same bit
      mask_q <= ((mask_q | set_v) & ~clr_v) & VALID;
      stk_q  <= ((rd_clr ? '0 : stk_q) | src_evt) & KEEP;
    end
  end

  p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
    (set_stb && !clr_stb) |=> ((mask_q & $past(wdata & VALID)) == $past(wdata & VALID)));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((mask_q & $past(wdata)) == '0));

  p_mask_keep_r9: assert property (@(posedge clk) disable iff (rst)
    !(set_stb || clr_stb) |=> $stable(mask_q));

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> (($past(stk_q) & ~stk_q) == '0));

  p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ((mask_q & ~VALID) == '0) && ((sts_o & ~VALID) == '0));

endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
  import aud_irq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_vld,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] tx_rdy_i,
  input  logic [NCH-1:0] tx_unf_i,
  input  logic [NCH-1:0] rx_rdy_i,
  input  logic [NCH-1:0] rx_ovf_i,
  input  logic           wr_err_i,
  input  logic           txf_rdy_i,
  input  logic           txf_emp_i,
  input  logic           rxf_rdy_i,
  input  logic           rxf_ful_i,
  output logic           irq_o
);

  localparam logic [DW-1:0] VAL_A = grp_a_valid(NCH);
  localparam logic [DW-1:0] STK_A = grp_a_sticky(NCH);
  localparam logic [DW-1:0] VAL_B = grp_b_valid();
  localparam logic [DW-1:0] STK_B = grp_b_sticky();

  logic [NGRP-1:0][DW-1:0] lvl, evt, mask, sts;
  logic [NGRP-1:0]         set_stb, clr_stb, rdclr_stb, pend;
  logic                    irq_q;

  // place source signals at their bit positions
  always_comb begin
    lvl = '0;
    evt = '0;
    for (int c = 0; c < int'(NCH); c++) begin
      lvl[0][FA_TXRDY + c] = tx_rdy_i[c];
      lvl[0][FA_RXRDY + c] = rx_rdy_i[c];
      evt[0][FA_TXUNF + c] = tx_unf_i[c];
      evt[0][FA_RXOVF + c] = rx_ovf_i[c];
    end
    evt[1][FB_WERR]   = wr_err_i;
    lvl[1][FB_TXFRDY] = txf_rdy_i;
    lvl[1][FB_TXFEMP] = txf_emp_i;
    lvl[1][FB_RXFRDY] = rxf_rdy_i;
    lvl[1][FB_RXFFUL] = rxf_ful_i;
  end

  aud_irq_regif #(.P_AW(AW), .P_DW(DW), .P_NGRP(NGRP)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_vld   (bus_vld),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .grp_mask  (mask),
    .grp_sts   (sts),
    .set_stb   (set_stb),
    .clr_stb   (clr_stb),
    .rdclr_stb (rdclr_stb),
    .rdata_q   (bus_rdata)
  );

  for (genvar g = 0; g < int'(NGRP); g++) begin : g_bank
    localparam logic [DW-1:0] V = (g == 0) ? VAL_A : VAL_B;
    localparam logic [DW-1:0] S = (g == 0) ? STK_A : STK_B;
    aud_irq_bank #(.P_DW(DW), .VALID(V), .STICKY(S)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_lvl (lvl[g]),
      .src_evt (evt[g]),
      .set_stb (set_stb[g]),
      .clr_stb (clr_stb[g]),
      .rd_clr  (rdclr_stb[g]),
      .wdata   (bus_wdata),
      .mask_q  (mask[g]),
      .sts_o   (sts[g]),
      .pend_o  (pend[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end

  assign irq_o = irq_q;

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (|pend) |=> irq_o);

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |=> !irq_o);

endmodule

// File: tb/aud_irq_ctrl_test.sv
`timescale 1ns/1ps
module aud_irq_ctrl_test;

  localparam int NCH = 8;
  localparam time TCK = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_vld = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] tx_rdy = '0, tx_unf = '0, rx_rdy = '0, rx_ovf = '0;
  logic wr_err = 0, txf_rdy = 0, txf_emp = 0, rxf_rdy = 0, rxf_ful = 0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;

  always #(TCK/2) clk = ~clk;

  aud_irq_ctrl #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_rdy_i(tx_rdy), .tx_unf_i(tx_unf), .rx_rdy_i(rx_rdy), .rx_ovf_i(rx_ovf),
    .wr_err_i(wr_err), .txf_rdy_i(txf_rdy), .txf_emp_i(txf_emp),
    .rxf_rdy_i(rxf_rdy), .rxf_ful_i(rxf_ful), .irq_o(irq)
  );

  // behavioural reference model
  bit [31:0] m_mask_a, m_mask_b, m_stk_a, m_stk_b, e_rdata;
  bit        e_irq;

  always @(posedge clk) begin
    bit [31:0] la, lb, ea, va, vb;
    if (rst) begin
      m_mask_a = 0; m_mask_b = 0; m_stk_a = 0; m_stk_b = 0; e_rdata = 0; e_irq = 0;
    end else begin
      la = 0; ea = 0; lb = 0;
      for (int c = 0; c < NCH; c++) begin
        la[c] = tx_rdy[c]; la[16+c] = rx_rdy[c];
        ea[8+c] = tx_unf[c]; ea[24+c] = rx_ovf[c];
      end
      lb[8] = txf_rdy; lb[9] = txf_emp; lb[12] = rxf_rdy; lb[13] = rxf_ful;
      va = la | m_stk_a;
      vb = lb | m_stk_b;
      e_irq = ((m_mask_a & va) != 0) || ((m_mask_b & vb) != 0);
      if (bus_vld && !bus_wr) begin
        case (bus_addr)
          8'h18: e_rdata = m_mask_a;
          8'h1C: e_rdata = va;
          8'h28: e_rdata = m_mask_b;
          8'h2C: e_rdata = vb;
          default: e_rdata = 0;
        endcase
      end
      if (bus_vld && !bus_wr && bus_addr == 8'h1C) m_stk_a = 0;
      if (bus_vld && !bus_wr && bus_addr == 8'h2C) m_stk_b = 0;
      m_stk_a |= ea;
      m_stk_b |= {31'd0, wr_err};
      if (bus_vld && bus_wr) begin
        case (bus_addr)
          8'h10: m_mask_a |= bus_wdata;
          8'h14: m_mask_a &= ~bus_wdata;
          8'h20: m_mask_b |= bus_wdata & 32'h0000_3301;
          8'h24: m_mask_b &= ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (model_on) begin
      chk("R10 rdata vs model", bus_rdata, e_rdata);
      chk("R8 irq vs model", {31'd0, irq}, {31'd0, e_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_vld = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_vld = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_vld = 0;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(TCK * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk); @(posedge clk);
    model_on = 1;
    @(negedge clk);
    chk("R1 reset rdata", bus_rdata, 32'h0);
    chk("R1 reset irq", {31'd0, irq}, 32'h0);
    rst = 0;
    rd(8'h18, 32'h0, "R1 mask A after reset");
    rd(8'h28, 32'h0, "R1 mask B after reset");
    rd(8'h1C, 32'h0, "R1 status A after reset");

    wr(8'h10, 32'h0000_00F0);
    rd(8'h18, 32'h0000_00F0, "R2 enable A");
    wr(8'h10, 32'h0F00_0001);
    rd(8'h18, 32'h0F00_00F1, "R2 enable A keeps zeros");
    wr(8'h14, 32'h0000_0030);
    rd(8'h18, 32'h0F00_00C1, "R3 disable A");
    rd(8'h10, 32'h0, "R9 enable reg reads zero");

    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h28, 32'h0000_3301, "R5 mask B unused bits zero");
    wr(8'h24, 32'h0000_0100);
    rd(8'h28, 32'h0000_3201, "R3 disable B");

    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0F00_00C1, "R9 writes to read-only ignored");
    rd(8'h40, 32'h0, "R9 unmapped read zero");
    wr(8'h00, 32'h0);
    #1 chk("R10 rdata held over write", bus_rdata, 32'h0);

    @(negedge clk); tx_rdy = 8'h05; rx_rdy = 8'hA0;
    rd(8'h1C, 32'h00A0_0005, "R4 level fields A");
    rd(8'h1C, 32'h00A0_0005, "R6 level bits not cleared by read");
    @(negedge clk); tx_rdy = 0; rx_rdy = 0;

    @(negedge clk); tx_unf = 8'h08; rx_ovf = 8'h80;
    @(negedge clk); tx_unf = 0; rx_ovf = 0;
    repeat (3) @(negedge clk);
    rd(8'h1C, 32'h8000_0800, "R7 sticky pulses held");
    rd(8'h1C, 32'h0, "R7 sticky cleared by read");

    @(negedge clk);
    bus_vld = 1; bus_wr = 0; bus_addr = 8'h1C; tx_unf = 8'h01;
    @(negedge clk);
    bus_vld = 0; tx_unf = 0;
    #1 chk("R7 read with same-cycle pulse", bus_rdata, 32'h0);
    rd(8'h1C, 32'h0000_0100, "R7 same-cycle pulse kept");

    @(negedge clk); wr_err = 1; txf_emp = 1;
    @(negedge clk); wr_err = 0;
    rd(8'h2C, 32'h0000_0201, "R5 group B fields");
    rd(8'h2C, 32'h0000_0200, "R6 level B kept, R7 sticky B cleared");
    @(negedge clk); txf_emp = 0;

    // irq latency
    @(negedge clk); tx_rdy = 8'h01;
    @(negedge clk); #1 chk("R8 irq one edge after level", {31'd0, irq}, 32'h1);
    wr(8'h14, 32'h0000_0001);
    @(negedge clk); #1 chk("R8 irq drops after mask clear", {31'd0, irq}, 32'h0);
    @(negedge clk); tx_rdy = 0;
    @(negedge clk); rx_ovf = 8'h01;
    @(negedge clk); rx_ovf = 0; #1 chk("R8 sticky not yet at irq", {31'd0, irq}, 32'h0);
    @(negedge clk); #1 chk("R8 irq two edges after pulse", {31'd0, irq}, 32'h1);
    rd(8'h1C, 32'h0100_0000, "R7 overflow ch0");
    @(negedge clk); #1 chk("R8 irq clears after status read", {31'd0, irq}, 32'h0);

    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    rd(8'h18, 32'h0, "R1 mask cleared by reset");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule